// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two direction predictors side by side and lets a table of selector counters pick which one to believe for each branch. The first predictor works from global history: it shifts the outcomes of the most recent branches into a register, XORs that register with word-address bits of the PC, and uses the result to index a table of 2-bit counters. The second predictor works from local history in two levels. It keeps a shift register of past outcomes for each branch, chosen by PC bits. That history, XORed with PC bits, selects a 3-bit counter. The selector table is indexed by the global history register. It holds 2-bit counters that lean toward global or toward local.

Fetch presents a PC on the lookup side. In the same cycle the block returns the final guess and a snapshot: each component's guess and which one was chosen. When the branch resolves, the pipeline presents the branch PC, the real outcome and that snapshot on the update side. Both component counters train toward the outcome. Both histories take in the outcome. The selector moves only when exactly one component was correct. Updates are applied in program order. No speculative history is kept.

Top module: `tourney_predictor`

## Requirements
- R1: After reset, every lookup returns not-taken on `lk_taken`, `lk_glob_pred` and `lk_loc_pred`, with `lk_use_local` = 0. Counters start at weakly-not-taken (2-bit value 1, 3-bit value 3), selectors start at 1 (weakly global), and all histories start at zero.
- R2: The global guess is bit 1 of the 2-bit counter at index `ghist ^ pc[GHIST_W+1:2]`. Here `ghist` is the global history register and bits [1:0] of the PC are ignored.
- R3: The local guess is bit 2 of the 3-bit counter at index `lhist ^ pc[LHIST_W+1:2]`. Here `lhist` is the history entry selected by `pc[LHT_ABITS+1:2]`.
- R4: On an update, the global counter and the local counter at the indices computed from the updated PC and the current histories each step by one toward the outcome. The 2-bit counter saturates at 0 and 3; the 3-bit counter saturates at 0 and 7.
- R5: On an update, the global history and the selected local history entry each shift left by one bit, and the outcome enters at bit 0.
- R6: The selector counter at index `ghist` is 2 bits wide; bit 1 = 1 chooses local. On an update it steps up (saturating) when the local snapshot matches the outcome and the global snapshot does not. It steps down (saturating) in the opposite case. Otherwise it does not change.
- R7: `lk_taken` equals `lk_loc_pred` when `lk_use_local` is 1 and `lk_glob_pred` otherwise. All lookup outputs are combinational from `lk_pc` and the state.
- R8: When a lookup and an update land in the same cycle, the lookup sees the state from before the update. The update takes effect at the clock edge.
- R9: Cycles with `up_valid` = 0 leave all state unchanged, whatever is on the lookup port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Fetch PC to predict |
| lk_taken | output | 1 | Final direction guess |
| lk_glob_pred | output | 1 | Global component guess (snapshot) |
| lk_loc_pred | output | 1 | Local component guess (snapshot) |
| lk_use_local | output | 1 | Selector chose the local component (snapshot) |
| up_valid | input | 1 | A resolved branch is presented |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome |
| up_glob_pred | input | 1 | Global guess recorded at lookup |
| up_loc_pred | input | 1 | Local guess recorded at lookup |

## Verification
A wrong counter step, a wrong history shift or a wrong selector move changes no output right away. It shows up on the next lookup that indexes the damaged entry. With history-hashed indices, that lookup may come many updates later, at an unrelated PC. The bench therefore compares all four lookup outputs with an arithmetic model before every update. It then sweeps every word PC after an idle stretch, so that a corruption is reported within one update of the lookup that exposes it.

// File: rtl/tp_pkg.sv
package tp_pkg;
  // Word-aligned PCs: the lowest index bit starts above the byte offset.
  localparam int unsigned PC_LSB = 2;

  typedef enum logic {
    SEL_GLOBAL = 1'b0,
    SEL_LOCAL  = 1'b1
  } sel_e;
endpackage

// File: rtl/tp_ctr_table.sv
// Table of saturating counters: one combinational read port for lookup,
// one read-modify-write port that steps an entry up or down.
module tp_ctr_table #(
  parameter int unsigned ABITS = 12,
  parameter int unsigned CW    = 2,
  parameter logic [CW-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ABITS-1:0] rd_idx,
  output logic             rd_msb,
  input  logic             wr_en,
  input  logic [ABITS-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int unsigned DEPTH = 1 << ABITS;
  localparam logic [CW-1:0] MAXV = '1;

  logic [CW-1:0] mem [DEPTH];
  logic [CW-1:0] cur_val;
  logic [CW-1:0] nxt_val;

  assign rd_msb  = mem[rd_idx][CW-1];
  assign cur_val = mem[wr_idx];

  always_comb begin
    nxt_val = cur_val;
    if (wr_up) begin
      if (cur_val != MAXV) nxt_val = cur_val + 1'b1;
    end else begin
      if (cur_val != '0) nxt_val = cur_val - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= nxt_val;
    end
  end
endmodule

// File: rtl/tp_hist_table.sv
// Per-branch outcome shift registers: a lookup read port and an update
// read port; the update port's entry takes the new outcome at bit 0.
module tp_hist_table #(
  parameter int unsigned ABITS = 10,
  parameter int unsigned HW    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ABITS-1:0] lk_idx,
  output logic [HW-1:0]    lk_hist,
  input  logic [ABITS-1:0] up_idx,
  output logic [HW-1:0]    up_hist,
  input  logic             wr_en,
  input  logic             wr_bit
);
  localparam int unsigned DEPTH = 1 << ABITS;

  logic [HW-1:0] mem [DEPTH];

  assign lk_hist = mem[lk_idx];
  assign up_hist = mem[up_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[up_idx] <= {up_hist[HW-2:0], wr_bit};
    end
  end
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tp_pkg::*;
#(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned GHIST_W   = 12,
  parameter int unsigned LHT_ABITS = 10,
  parameter int unsigned LHIST_W   = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic            lk_glob_pred,
  output logic            lk_loc_pred,
  output logic            lk_use_local,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_glob_pred,
  input  logic            up_loc_pred
);
  localparam int unsigned GCTR_W = 2;
  localparam int unsigned LCTR_W = 3;
  localparam int unsigned SEL_W  = 2;
  localparam logic [GCTR_W-1:0] GCTR_INIT = GCTR_W'(1);
  localparam logic [LCTR_W-1:0] LCTR_INIT = LCTR_W'(3);
  localparam logic [SEL_W-1:0]  SEL_INIT  = SEL_W'(1);

  logic [GHIST_W-1:0] ghist_q;

  // Lookup-side indices
  logic [GHIST_W-1:0]   lk_gidx;
  logic [LHT_ABITS-1:0] lk_hidx;
  logic [LHIST_W-1:0]   lk_lhist;
  logic [LHIST_W-1:0]   lk_lidx;
  // Update-side indices
  logic [GHIST_W-1:0]   up_gidx;
  logic [LHT_ABITS-1:0] up_hidx;
  logic [LHIST_W-1:0]   up_lhist;
  logic [LHIST_W-1:0]   up_lidx;

  logic glob_ok, loc_ok, sel_we, sel_msb;
  sel_e lk_sel;
  logic unused_pc_bits;

  assign unused_pc_bits = ^{lk_pc, up_pc};

  assign lk_gidx = ghist_q ^ lk_pc[PC_LSB +: GHIST_W];
  assign lk_hidx = lk_pc[PC_LSB +: LHT_ABITS];
  assign lk_lidx = lk_lhist ^ lk_pc[PC_LSB +: LHIST_W];

  assign up_gidx = ghist_q ^ up_pc[PC_LSB +: GHIST_W];
  assign up_hidx = up_pc[PC_LSB +: LHT_ABITS];
  assign up_lidx = up_lhist ^ up_pc[PC_LSB +: LHIST_W];

  // Selector trains only when the components disagree in correctness.
  assign glob_ok = (up_glob_pred == up_taken);
  assign loc_ok  = (up_loc_pred == up_taken);
  assign sel_we  = up_valid && (glob_ok != loc_ok);

  tp_ctr_table #(.ABITS(GHIST_W), .CW(GCTR_W), .INIT(GCTR_INIT)) u_glob (
    .clk(clk), .rst(rst),
    .rd_idx(lk_gidx), .rd_msb(lk_glob_pred),
    .wr_en(up_valid), .wr_idx(up_gidx), .wr_up(up_taken)
  );

  tp_hist_table #(.ABITS(LHT_ABITS), .HW(LHIST_W)) u_lhist (
    .clk(clk), .rst(rst),
    .lk_idx(lk_hidx), .lk_hist(lk_lhist),
    .up_idx(up_hidx), .up_hist(up_lhist),
    .wr_en(up_valid), .wr_bit(up_taken)
  );

  tp_ctr_table #(.ABITS(LHIST_W), .CW(LCTR_W), .INIT(LCTR_INIT)) u_loc (
    .clk(clk), .rst(rst),
    .rd_idx(lk_lidx), .rd_msb(lk_loc_pred),
    .wr_en(up_valid), .wr_idx(up_lidx), .wr_up(up_taken)
  );

  tp_ctr_table #(.ABITS(GHIST_W), .CW(SEL_W), .INIT(SEL_INIT)) u_sel (
    .clk(clk), .rst(rst),
    .rd_idx(ghist_q), .rd_msb(sel_msb),
    .wr_en(sel_we), .wr_idx(ghist_q), .wr_up(loc_ok)
  );

  assign lk_sel       = sel_e'(sel_msb);
  assign lk_use_local = (lk_sel == SEL_LOCAL);
  assign lk_taken     = (lk_sel == SEL_LOCAL) ? lk_loc_pred : lk_glob_pred;

  always_ff @(posedge clk) begin
    if (rst) begin
      ghist_q <= '0;
    end else if (up_valid) begin
      ghist_q <= {ghist_q[GHIST_W-2:0], up_taken};
    end
  end
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned GHIST_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic [PC_W-1:0]    lk_pc,
  input logic               lk_taken,
  input logic               lk_glob_pred,
  input logic               lk_loc_pred,
  input logic               lk_use_local,
  input logic               up_valid,
  input logic               up_taken,
  input logic [GHIST_W-1:0] ghist
);
  // R1: reset clears the global history
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (ghist == '0));

  // R5: an update shifts the outcome in at bit 0
  p_hist_shift_r5: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> (ghist == {$past(ghist[GHIST_W-2:0]), $past(up_taken)}));

  // R9: no update, no history change
  p_hist_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> $stable(ghist));

  // R9: without an update, an unchanged lookup PC gives an unchanged guess
  p_guess_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> (!$stable(lk_pc) || ($stable(lk_taken) && $stable(lk_use_local))));

  // R7: lookup outputs are always driven to known values
  p_known_r7: assert property (@(posedge clk) disable iff (rst)
    !$isunknown({lk_taken, lk_glob_pred, lk_loc_pred, lk_use_local}));
endmodule

bind tourney_predictor tp_checker #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_chk (
  .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken),
  .lk_glob_pred(lk_glob_pred), .lk_loc_pred(lk_loc_pred),
  .lk_use_local(lk_use_local), .up_valid(up_valid), .up_taken(up_taken),
  .ghist(ghist_q)
);

// File: tb/sim_tourney_predictor.sv
`timescale 1ns/1ps
module sim_tourney_predictor;
  localparam int unsigned PW = 12;
  localparam int unsigned GW = 4;
  localparam int unsigned LA = 3;
  localparam int unsigned LW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0] lk_pc = '0;
  logic lk_taken, lk_glob_pred, lk_loc_pred, lk_use_local;
  logic up_valid = 1'b0;
  logic [PW-1:0] up_pc = '0;
  logic up_taken = 1'b0, up_glob_pred = 1'b0, up_loc_pred = 1'b0;

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  // Reference state, maintained from the requirements
  logic [1:0]    gm  [1<<GW];
  logic [2:0]    lm  [1<<LW];
  logic [1:0]    ch  [1<<GW];
  logic [LW-1:0] lht [1<<LA];
  logic [GW-1:0] gh;

  always #2 clk = ~clk;

  tourney_predictor #(.PC_W(PW), .GHIST_W(GW), .LHT_ABITS(LA), .LHIST_W(LW)) u0 (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_glob_pred(lk_glob_pred), .lk_loc_pred(lk_loc_pred),
    .lk_use_local(lk_use_local), .up_valid(up_valid), .up_pc(up_pc),
    .up_taken(up_taken), .up_glob_pred(up_glob_pred), .up_loc_pred(up_loc_pred)
  );

  function automatic logic [15:0] next_rand(input logic [15:0] s);
    logic [15:0] x = s;
    x = x ^ (x << 7);
    x = x ^ (x >> 9);
    x = x ^ (x << 8);
    return x;
  endfunction

  // {taken, glob, loc, use_local}
  function automatic logic [3:0] model_lookup(input logic [PW-1:0] pc);
    logic [GW-1:0] gi = gh ^ pc[GW+1:2];
    logic [LW-1:0] li = lht[pc[LA+1:2]] ^ pc[LW+1:2];
    logic g = gm[gi][1];
    logic l = lm[li][2];
    logic s = ch[gh][1];
    return {(s ? l : g), g, l, s};
  endfunction

  task automatic model_update(input logic [PW-1:0] pc, input logic t,
                              input logic gp, input logic lp);
    logic [GW-1:0] gi = gh ^ pc[GW+1:2];
    logic [LA-1:0] hi = pc[LA+1:2];
    logic [LW-1:0] li = lht[hi] ^ pc[LW+1:2];
    if (t) begin
      if (gm[gi] != 2'd3) gm[gi] = gm[gi] + 2'd1;
      if (lm[li] != 3'd7) lm[li] = lm[li] + 3'd1;
    end else begin
      if (gm[gi] != 2'd0) gm[gi] = gm[gi] - 2'd1;
      if (lm[li] != 3'd0) lm[li] = lm[li] - 3'd1;
    end
    if ((lp == t) && (gp != t) && ch[gh] != 2'd3) ch[gh] = ch[gh] + 2'd1;
    if ((gp == t) && (lp != t) && ch[gh] != 2'd0) ch[gh] = ch[gh] - 2'd1;
    lht[hi] = {lht[hi][LW-2:0], t};
    gh = {gh[GW-2:0], t};
  endtask

  task automatic model_reset();
    for (int i = 0; i < (1<<GW); i++) begin gm[i] = 2'd1; ch[i] = 2'd1; end
    for (int i = 0; i < (1<<LW); i++) lm[i] = 3'd3;
    for (int i = 0; i < (1<<LA); i++) lht[i] = '0;
    gh = '0;
  endtask

  // One cycle: drive at the falling edge, check lookup before the rising edge.
  task automatic step(input string tag, input logic [PW-1:0] lpc, input logic upv,
                      input logic [PW-1:0] upc, input logic t, input logic flip_snap);
    logic [3:0] exp_lk, snap;
    @(negedge clk);
    snap = model_lookup(upc);
    lk_pc        = lpc;
    up_valid     = upv;
    up_pc        = upc;
    up_taken     = t;
    up_glob_pred = snap[2] ^ flip_snap;
    up_loc_pred  = snap[1];
    #1;
    exp_lk = model_lookup(lpc);
    n_checks++;
    if ({lk_taken, lk_glob_pred, lk_loc_pred, lk_use_local} !== exp_lk) begin
      n_fails++;
      $display("FAIL %s pc=%h actual=%b expected=%b", tag, lpc,
               {lk_taken, lk_glob_pred, lk_loc_pred, lk_use_local}, exp_lk);
    end
    if (upv) model_update(upc, t, snap[2] ^ flip_snap, snap[1]);
  endtask

  task automatic sweep(input string tag);
    for (int w = 0; w < 64; w++) step(tag, PW'(w << 2), 1'b0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state at every word PC (low byte-offset bits varied too)
    sweep("R1 reset");
    step("R1 offset bits", 12'h013, 1'b0, '0, 1'b0, 1'b0);

    // R4: saturation upward then downward at one branch, collision each cycle (R8)
    for (int i = 0; i < 12; i++) step("R4 R8 saturate up", 12'h010, 1'b1, 12'h010, 1'b1, 1'b0);
    for (int i = 0; i < 12; i++) step("R4 R8 saturate down", 12'h010, 1'b1, 12'h010, 1'b0, 1'b0);

    // R3: alternating pattern at one branch, learned by the local side
    for (int i = 0; i < 60; i++) step("R3 R6 alternating", 12'h024, 1'b1, 12'h024, i[0], 1'b0);

    // R2 R5 R6 R7: mixed traffic, lookup PC sometimes differs from update PC,
    // snapshots sometimes deliberately disagree with the state
    for (int i = 0; i < 3000; i++) begin
      logic [PW-1:0] pa, pb;
      logic t;
      lfsr = next_rand(lfsr);
      pa = PW'({lfsr[5:0], 2'b00});
      pb = lfsr[8] ? PW'({lfsr[14:9], lfsr[1:0]}) : pa;
      t  = lfsr[6] ^ (lfsr[7] & pa[2]);
      step("R2 R5 R6 R7 mixed", pb, 1'b1, pa, t, lfsr[15] & lfsr[3]);
    end

    // R9: idle cycles with wandering lookup PC, then a full sweep
    for (int i = 0; i < 50; i++) begin
      lfsr = next_rand(lfsr);
      step("R9 idle", lfsr[PW-1:0], 1'b0, lfsr[PW-1:0], lfsr[0], 1'b0);
    end
    sweep("R9 after idle");

    // R1: second reset returns everything to the initial state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    sweep("R1 re-reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #800000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule